// File: doc/BRIEF.md
# LVDS Lane Bit-Mapping Serializer

This block turns one 28-bit parallel pixel word into 7-bit symbols for four LVDS data lanes and one clock lane. The pixel word holds 24 colour bits plus sync, data-enable and spare control bits. Each of the seven bit slots of each data lane has its own 5-bit selector, which names the bit of the pixel word that the slot carries. A bit-rate strobe shifts the symbols out one slot per strobe, seven strobes per pixel. While the lanes run, the clock lane sends a fixed pattern that stays aligned with the data symbols.

Software first writes the selectors and a control byte through a simple write port. That byte enables the interface, the clock lane and each data lane. It also carries a mode flag that a downstream block reads. Serialization starts only after a separate enable bit is set, usually in a later write. The mapping is copied into a working set at each symbol boundary, so a write made in the middle of a symbol never splits one symbol between two mappings.

A two-state machine controls the outputs. ST_IDLE holds every output low and resets the slot counter. ST_RUN shifts symbols. The transition ST_IDLE to ST_RUN happens when the interface enable and the serialization enable are both set. The transition ST_RUN to ST_IDLE happens as soon as either of them is cleared.

Top module: `lvds_lane_mapper`

## Requirements
- R1: After reset, lane_out, clk_lane_out, sym_first and rgb_mode are all low, the control byte is zero, and every selector holds its R5 default.
- R2: Symbols are sent only while control bit 0 (interface enable) and control bit 2 (serialization enable) are both 1. Otherwise every data lane and the clock lane are low by the second clock edge after the write that cleared either bit.
- R3: While running, each bit_stb moves the outputs on by one slot, slot 0 first and slot 6 last. A symbol is seven strobes long, and sym_first is high exactly while slot 0 is on the outputs.
- R4: Slot s of lane l carries pix_word[sel(l,s)]. The pixel word is sampled at the strobe that emits slot 0, and later changes within the same symbol have no effect.
- R5: The default selectors for slots 0..6 are: lane 0 = 08,05,04,03,02,01,00; lane 1 = 11,10,0D,0C,0B,0A,09; lane 2 = 1A,19,18,15,14,13,12; lane 3 = 1B,17,16,0F,0E,07,06 (hex).
- R6: A selector value above 27 (0x1B) makes the slot carry a constant 0.
- R7: A data lane whose enable bit is 0 outputs a constant 0, even while serialization runs.
- R8: When control bit 1 is set, the clock lane sends the pattern 1,1,0,0,0,1,1 over slots 0..6 of every symbol. When bit 1 is clear, the clock lane is 0.
- R9: Selector writes made during a symbol take effect from the next symbol's slot 0 and never alter the symbol already in progress.
- R10: A write with wr_addr[5]=0 sets the selector of lane wr_addr[4:3], slot wr_addr[2:0] to wr_data[4:0]. Slot address 7 is ignored and changes no selector.
- R11: A write with wr_addr[5]=1 loads the control byte: bit 0 interface enable, bit 1 clock-lane enable, bit 2 serialization enable, bit 3 RGB-output mode flag, bits 7:4 data-lane enables (bit 4 = lane 0). rgb_mode follows bit 3 one edge after the write.
- R12: When serialization is enabled again after a stop in the middle of a symbol, the next symbol starts at slot 0 with a newly sampled pixel word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serializer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | Bit-rate strobe; one slot per strobe |
| pix_word | input | 28 | Parallel pixel word (colour, sync, data enable, spare) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address: bit 5 selects control, else lane/slot |
| wr_data | input | 8 | Write data |
| lane_out | output | 4 | Serial data lane outputs |
| clk_lane_out | output | 1 | Serial clock lane output |
| sym_first | output | 1 | High while slot 0 is on the outputs |
| rgb_mode | output | 1 | RGB-output mode flag from the control byte |

## Verification
On every cycle, the assertions check the following: outputs stay quiet in ST_IDLE, disabled lanes stay at zero, sym_first appears on the slot-0 strobe, the clock lane is low in slot 2, the working mapping is frozen between symbol boundaries, slot-7 writes are ignored, and the mode flag follows the control byte. Only the bench scenarios can show the bit values of whole symbols, because that needs an independent model of the selector table. These scenarios cover the default and 18-bit mappings, the out-of-range selectors, the sampling point of the pixel word, a mapping change in the middle of a symbol, and a stop followed by a restart in the middle of a symbol.

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;

    localparam int LANES_DEF = 4;
    localparam int SLOTS_DEF = 7;
    localparam int SELW_DEF  = 5;
    localparam int WORD_DEF  = 28;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ser_state_e;

    // Default 24-bit selectors, packed slot 6 (MSB) down to slot 0 (LSB).
    localparam logic [34:0] DEF_L0 = {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h08};
    localparam logic [34:0] DEF_L1 = {5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h10, 5'h11};
    localparam logic [34:0] DEF_L2 = {5'h12, 5'h13, 5'h14, 5'h15, 5'h18, 5'h19, 5'h1A};
    localparam logic [34:0] DEF_L3 = {5'h06, 5'h07, 5'h0E, 5'h0F, 5'h16, 5'h17, 5'h1B};

    function automatic logic [4:0] def_sel(input int lane, input int slot);
        logic [34:0] row;
        case (lane)
            0:       row = DEF_L0;
            1:       row = DEF_L1;
            2:       row = DEF_L2;
            3:       row = DEF_L3;
            default: row = '0;
        endcase
        if (slot < 0 || slot > 6) return 5'h00;
        return row[slot*5 +: 5];
    endfunction

endpackage

// File: rtl/lvds_map_regs.sv
module lvds_map_regs
    import lvds_map_pkg::*;
#(
    parameter int NLANE = LANES_DEF,
    parameter int NSLOT = SLOTS_DEF,
    parameter int SELW  = SELW_DEF,
    parameter int ADDRW = 6,
    parameter int CTRLW = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDRW-1:0]                       wr_addr,
    input  logic [CTRLW-1:0]                       wr_data,
    output logic [NLANE-1:0][NSLOT-1:0][SELW-1:0]  map_q,
    output logic                                   intf_en,
    output logic                                   clk_en,
    output logic                                   ser_en,
    output logic                                   rgb_mode,
    output logic [NLANE-1:0]                       lane_en
);

    localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1;
    localparam int SW = $clog2(NSLOT + 1);

    logic [CTRLW-1:0] ctrl_q;
    logic             is_ctrl;
    logic [LW-1:0]    a_lane;
    logic [SW-1:0]    a_slot;

    assign is_ctrl = wr_addr[ADDRW-1];
    assign a_lane  = wr_addr[SW +: LW];
    assign a_slot  = wr_addr[SW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int l = 0; l < NLANE; l++) begin
                for (int s = 0; s < NSLOT; s++) begin
                    map_q[l][s] <= SELW'(def_sel(l, s));
                end
            end
        end else if (wr_en) begin
            if (is_ctrl) begin
                ctrl_q <= wr_data;
            end else if (a_slot < SW'(NSLOT)) begin
                map_q[a_lane][a_slot] <= wr_data[SELW-1:0];
            end
        end
    end

    assign intf_en  = ctrl_q[0];
    assign clk_en   = ctrl_q[1];
    assign ser_en   = ctrl_q[2];
    assign rgb_mode = ctrl_q[3];
    assign lane_en  = ctrl_q[4 +: NLANE];

    // R10
    slot_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[ADDRW-1] && (wr_addr[SW-1:0] >= SW'(NSLOT))) |=> $stable(map_q));

    // R11
    mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDRW-1]) |=> (rgb_mode == $past(wr_data[3])));

endmodule

// File: rtl/lvds_bit_pick.sv
module lvds_bit_pick #(
    parameter int WORDW = 28,
    parameter int SELW  = 5
) (
    input  logic [WORDW-1:0] word,
    input  logic [SELW-1:0]  sel,
    input  logic             en,
    output logic             bit_o
);

    localparam logic [SELW-1:0] TOP_SEL = SELW'(WORDW - 1);

    always_comb begin
        bit_o = 1'b0;
        if (en && (sel <= TOP_SEL)) begin
            bit_o = word[sel];
        end
    end

endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
    import lvds_map_pkg::*;
#(
    parameter int NLANE   = LANES_DEF,
    parameter int NSLOT   = SLOTS_DEF,
    parameter int SELW    = SELW_DEF,
    parameter int WORDW   = WORD_DEF,
    parameter logic [NSLOT-1:0] CLK_PAT = 7'b1100011,
    localparam int LW     = (NLANE > 1) ? $clog2(NLANE) : 1,
    localparam int SW     = $clog2(NSLOT + 1),
    localparam int ADDRW  = 1 + LW + SW,
    localparam int CTRLW  = 4 + NLANE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic [WORDW-1:0]  pix_word,
    input  logic              wr_en,
    input  logic [ADDRW-1:0]  wr_addr,
    input  logic [CTRLW-1:0]  wr_data,
    output logic [NLANE-1:0]  lane_out,
    output logic              clk_lane_out,
    output logic              sym_first,
    output logic              rgb_mode
);

    localparam int PHW = $clog2(NSLOT);
    localparam logic [PHW-1:0] LAST_PH = PHW'(NSLOT - 1);

    logic [NLANE-1:0][NSLOT-1:0][SELW-1:0] map_q;
    logic [NLANE-1:0][NSLOT-1:0][SELW-1:0] map_act;
    logic [NLANE-1:0][NSLOT-1:0][SELW-1:0] src_map;
    logic [WORDW-1:0]  word_q;
    logic [WORDW-1:0]  src_word;
    logic              intf_en, clk_en, ser_en, run_req;
    logic [NLANE-1:0]  lane_en;
    logic [NLANE-1:0]  pick;
    logic [NLANE-1:0]  lane_q;
    logic              clk_q, first_q;
    logic [PHW-1:0]    phase_q;
    ser_state_e        state_q, state_d;

    lvds_map_regs #(
        .NLANE (NLANE),
        .NSLOT (NSLOT),
        .SELW  (SELW),
        .ADDRW (ADDRW),
        .CTRLW (CTRLW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .map_q    (map_q),
        .intf_en  (intf_en),
        .clk_en   (clk_en),
        .ser_en   (ser_en),
        .rgb_mode (rgb_mode),
        .lane_en  (lane_en)
    );

    assign run_req = intf_en & ser_en;

    // At slot 0 the live word and mapping feed the pickers; later slots use the held copies.
    assign src_word = (phase_q == '0) ? pix_word : word_q;
    assign src_map  = (phase_q == '0) ? map_q    : map_act;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        lvds_bit_pick #(
            .WORDW (WORDW),
            .SELW  (SELW)
        ) u_pick (
            .word  (src_word),
            .sel   (src_map[i][phase_q]),
            .en    (lane_en[i]),
            .bit_o (pick[i])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_req)  state_d = ST_RUN;
            ST_RUN:  if (!run_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q  <= '0;
            clk_q   <= 1'b0;
            first_q <= 1'b0;
            phase_q <= '0;
            word_q  <= '0;
            map_act <= '0;
        end else if (state_q != ST_RUN || !run_req) begin
            lane_q  <= '0;
            clk_q   <= 1'b0;
            first_q <= 1'b0;
            phase_q <= '0;
        end else if (bit_stb) begin
            lane_q  <= pick;
            clk_q   <= clk_en & CLK_PAT[phase_q];
            first_q <= (phase_q == '0);
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
            if (phase_q == '0) begin
                word_q  <= pix_word;
                map_act <= map_q;
            end
        end
    end

    assign lane_out     = lane_q;
    assign clk_lane_out = clk_q;
    assign sym_first    = first_q;

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (lane_out == '0 && !clk_lane_out && !sym_first));

    // R7
    dis_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_req && bit_stb) |=> ((lane_out & ~$past(lane_en)) == '0));

    // R3
    first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_req && bit_stb && phase_q == '0) |=> sym_first);

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST_PH);

    // R8
    clk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_req && bit_stb && phase_q == PHW'(2)) |=> !clk_lane_out);

    // R9
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != '0) |=> $stable(map_act));

endmodule

// File: tb/test_lvds_lane_mapper.sv
module test_lvds_lane_mapper;

    localparam logic [6:0] PAT = 7'b1100011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic [27:0] pix_word = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  lane_out;
    logic        clk_lane_out;
    logic        sym_first;
    logic        rgb_mode;

    int n_chk = 0;
    int n_fail = 0;

    int         bm [4][7];
    logic [7:0] cfg = 8'h00;
    logic [6:0] g_lane [4];
    logic [6:0] g_clk;
    bit         g_first_ok;

    always #4 clk = ~clk;

    lvds_lane_mapper i_lvds_lane_mapper (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_stb      (bit_stb),
        .pix_word     (pix_word),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .lane_out     (lane_out),
        .clk_lane_out (clk_lane_out),
        .sym_first    (sym_first),
        .rgb_mode     (rgb_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        int d [4][7] = '{'{8, 5, 4, 3, 2, 1, 0},
                         '{17, 16, 13, 12, 11, 10, 9},
                         '{26, 25, 24, 21, 20, 19, 18},
                         '{27, 23, 22, 15, 14, 7, 6}};
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 7; s++) bm[l][s] = d[l][s];
        cfg = 8'h00;
    endtask

    task automatic model_wr(input logic [5:0] a, input logic [7:0] d);
        if (a[5]) cfg = d;
        else if (a[2:0] != 3'd7) bm[a[4:3]][a[2:0]] = int'(d[4:0]);
    endtask

    task automatic wrm(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    function automatic logic [6:0] exp_lane(input int l, input logic [27:0] w);
        logic [6:0] r;
        bit run;
        run = cfg[0] && cfg[2];
        for (int s = 0; s < 7; s++)
            r[s] = (run && cfg[4+l] && bm[l][s] < 28) ? w[bm[l][s]] : 1'b0;
        return r;
    endfunction

    task automatic run_sym(input logic [27:0] w, input logic [27:0] wl, input bit mw,
                           input logic [5:0] ma, input logic [7:0] md);
        bit run;
        run = cfg[0] && cfg[2];
        g_first_ok = 1'b1;
        for (int s = 0; s < 7; s++) begin
            @(negedge clk);
            pix_word = (s == 0) ? w : wl;
            bit_stb  = 1'b1;
            wr_en    = mw && (s == 3);
            wr_addr  = ma;
            wr_data  = md;
            @(posedge clk);
            #1;
            for (int l = 0; l < 4; l++) g_lane[l][s] = lane_out[l];
            g_clk[s] = clk_lane_out;
            if (sym_first != (run && s == 0)) g_first_ok = 1'b0;
        end
        @(negedge clk);
        bit_stb = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic check_sym(input logic [27:0] w, input logic [27:0] wl, input string req);
        logic [6:0] e;
        logic [6:0] ec;
        run_sym(w, wl, 1'b0, 6'h00, 8'h00);
        for (int l = 0; l < 4; l++) begin
            e = exp_lane(l, w);
            chk(g_lane[l] == e, req, $sformatf("lane%0d word=%h", l, w), 32'(g_lane[l]), 32'(e));
        end
        ec = (cfg[0] && cfg[2] && cfg[1]) ? PAT : 7'h00;
        chk(g_clk == ec, "R8", "clock lane pattern", 32'(g_clk), 32'(ec));
        chk(g_first_ok, "R3", "sym_first on slot 0 only", 32'(g_first_ok), 32'd1);
    endtask

    task automatic t_reset();
        chk(lane_out == 4'h0, "R1", "lane_out after reset", 32'(lane_out), 32'h0);
        chk(!clk_lane_out, "R1", "clk lane after reset", 32'(clk_lane_out), 32'h0);
        chk(!sym_first, "R1", "sym_first after reset", 32'(sym_first), 32'h0);
        chk(!rgb_mode, "R1", "rgb_mode after reset", 32'(rgb_mode), 32'h0);
    endtask

    task automatic t_no_ser();
        wrm(6'h20, 8'hF3);
        check_sym(28'hFFFFFFF, 28'hFFFFFFF, "R2");
    endtask

    task automatic t_default24();
        wrm(6'h20, 8'hF7);
        check_sym(28'h0000100, 28'h0000100, "R5");
        check_sym(28'hABCDEF1, 28'hABCDEF1, "R1");
        check_sym(28'hFFFFFFF, 28'hFFFFFFF, "R4");
        check_sym(28'h8000001, 28'h8000001, "R5");
        check_sym(28'h5A5A5A5, 28'hA5A5A5A, "R4");
    endtask

    task automatic t_mode18();
        int t18 [3][7] = '{'{10, 7, 6, 5, 4, 3, 2},
                           '{19, 18, 15, 14, 13, 12, 11},
                           '{26, 25, 24, 23, 22, 21, 20}};
        for (int l = 0; l < 3; l++)
            for (int s = 0; s < 7; s++)
                wrm({1'b0, 2'(l), 3'(s)}, 8'(t18[l][s]));
        wrm(6'h20, 8'h7F);
        chk(rgb_mode, "R11", "rgb_mode set", 32'(rgb_mode), 32'h1);
        check_sym(28'hFFFFFFF, 28'hFFFFFFF, "R7");
        check_sym(28'h3C0F0F3, 28'h3C0F0F3, "R10");
    endtask

    task automatic t_sel_over();
        wrm(6'h02, 8'h1F);
        wrm(6'h0C, 8'h1C);
        check_sym(28'hFFFFFFF, 28'hFFFFFFF, "R6");
    endtask

    task automatic t_boundary();
        logic [6:0] e;
        logic [27:0] w;
        w = 28'h0200000;
        e = exp_lane(2, w);
        run_sym(w, w, 1'b1, 6'h15, 8'h00);
        chk(g_lane[2] == e, "R9", "old map kept mid-symbol", 32'(g_lane[2]), 32'(e));
        model_wr(6'h15, 8'h00);
        check_sym(w, w, "R9");
    endtask

    task automatic t_slot7();
        wrm(6'h07, 8'h1B);
        check_sym(28'h0000400, 28'h0000400, "R10");
    endtask

    task automatic t_stop_restart();
        logic [6:0] e;
        logic [6:0] ec;
        logic [27:0] w;
        w = 28'hFFFFFFF;
        for (int l = 0; l < 4; l++) begin
            e = exp_lane(l, w) & 7'h0F;
            g_lane[l] = 7'h00;
        end
        run_sym(w, w, 1'b1, 6'h20, 8'h7B);
        for (int l = 0; l < 4; l++) begin
            e = exp_lane(l, w) & 7'h0F;
            chk(g_lane[l] == e, "R2", $sformatf("lane%0d cut after stop", l), 32'(g_lane[l]), 32'(e));
        end
        ec = PAT & 7'h0F;
        chk(g_clk == ec, "R2", "clock lane cut after stop", 32'(g_clk), 32'(ec));
        model_wr(6'h20, 8'h7B);
        check_sym(w, w, "R2");
        wrm(6'h20, 8'h7F);
        check_sym(28'h1555555, 28'h2AAAAAA, "R12");
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_ser();
        t_default24();
        t_mode18();
        t_sel_over();
        t_boundary();
        t_slot7();
        t_stop_restart();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule